// File: doc/BRIEF.md
# Double-Rate Burst-of-Four Shared-Bus SRAM Core

This block is a synthesizable model of a static memory. Every access moves four data beats at double data rate over one logical data bus. The core runs on a single phase clock. Each clock edge stands for one half of the external memory clock. Phases 0 and 2 of every four-phase frame stand for rising K edges, and phases 1 and 3 stand for rising K# edges. A command names a group of four consecutive words. Only the first K edge of each frame accepts a command, so a new burst can start every two external cycles.

Writes use a late-write scheme. Write data arrives one external cycle after the command. The four beats are collected in a write buffer and are only committed to the array when the next write's first beat arrives. A read returns its four beats two and a half external cycles after its command. The read path merges any bytes still held in the write buffer, so a read always sees the newest data. Each write beat carries its own byte-lane enables. Illegal command patterns are dropped and raise a sticky error flag.

The bidirectional data bus is split into a write-data input, a read-data output and an output enable. The echo clocks are reduced to a strobe that toggles once per read beat.

Top module: `ddrb4_sram_core`

## Requirements
- R1: A command's group address selects four words; data beats 1 to 4 of that command map to word offsets 0, 1, 2, 3 of the group, in that order, for both reads and writes.
- R2: `cmd_slot` is high before exactly one edge in four. Only that edge accepts a command. The first edge after reset is such an edge.
- R3: For a write accepted on edge E0, beats 1 to 4 are sampled from `wr_data`/`wr_ben` on edges E2, E3, E4 and E5. Values on any other edge have no effect.
- R4: For a read accepted on edge E0, beat k (k = 1..4) is driven on `rd_data` by edge E(4+k), so the first beat appears 5 phases (2.5 external cycles) after the command.
- R5: `rd_vld` and `rd_oe` are high exactly in the phases that follow the edges driving read beats: four consecutive phases per read. Reads in adjacent slots give eight unbroken phases.
- R6: Bit b of `wr_ben` enables byte lane b, which is bits [9b+8:9b] of the data word. The enable applies per beat. A disabled lane keeps its stored byte.
- R7: A read returns the newest written bytes even while the last write is still in the write buffer and uncommitted. This includes two back-to-back partial writes to the same group followed at once by a read.
- R8: `proto_err` sets on, and stays set until reset, when any of these is seen: read and write both high on an accepting edge; a read or write on a non-accepting phase-2 edge; a write in the slot right after an accepted read. Any of these commands is ignored, with no memory change and no read beats. Commands on phase-1 and phase-3 edges are ignored and do not set the flag.
- R9: During and right after reset, `rd_vld`, `rd_oe`, `proto_err` and `echo_strb` are low, and the write buffer is empty.
- R10: `echo_strb` toggles on exactly the edges that drive a read beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock; each edge is one half external cycle |
| rst | input | 1 | Synchronous active-high reset |
| cmd_slot | output | 1 | High when the next edge accepts a command |
| cmd_rd | input | 1 | Read request |
| cmd_wr | input | 1 | Write request |
| cmd_grp | input | GRP_W | Four-word group address |
| wr_data | input | DATA_W | Write beat data |
| wr_ben | input | LANES | Per-beat byte-lane write enables, active high |
| rd_data | output | DATA_W | Read beat data |
| rd_oe | output | 1 | Data-bus output enable |
| rd_vld | output | 1 | Read beat valid |
| echo_strb | output | 1 | Toggles once per read beat |
| proto_err | output | 1 | Sticky protocol-violation flag |

## Verification
The core is first exercised with eight back-to-back full writes. These are followed by a read of the group still held in the write buffer, which separates a correct buffer merge from a read of stale array contents. Two partial writes to one group are then read at once. This shows that a commit and a merge both honour each beat's own lane mask, rather than a mask shared by the burst. Random bursts of reads, writes and idles follow, with random byte masks and noise data driven on every phase outside write beats. Any sampling on the wrong edge or wrong beat-to-offset order then shows as a data mismatch. Finally, each illegal command form is followed by a read or by the bus output in the slot where a result would have appeared, so that an ignored command can be told apart from one that slipped through.

// File: rtl/ddrb4_pkg.sv
package ddrb4_pkg;

    localparam int BYTE_W     = 9;
    localparam int BURST      = 4;
    localparam int RD_LAT_PH  = 5;
    localparam int WR_LEAD_PH = 2;

    typedef enum logic [1:0] {
        PH_OPEN   = 2'd0,
        PH_OPEN_N = 2'd1,
        PH_SHUT   = 2'd2,
        PH_SHUT_N = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_BOTH  = 2'd3
    } op_e;

    function automatic phase_e next_phase(input phase_e p);
        return phase_e'(p + 2'd1);
    endfunction

    function automatic op_e classify(input logic rd, input logic wr);
        return op_e'({wr, rd});
    endfunction

endpackage

// File: rtl/ddrb4_seq.sv
module ddrb4_seq
    import ddrb4_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmd_rd,
    input  logic cmd_wr,
    output logic slot,
    output logic acc_rd,
    output logic acc_wr,
    output logic err
);
    phase_e ph;
    logic   last_rd;
    op_e    op;
    logic   bad;

    always_comb begin
        op     = classify(cmd_rd, cmd_wr);
        slot   = (ph == PH_OPEN);
        acc_rd = slot && (op == OP_READ);
        acc_wr = slot && (op == OP_WRITE) && !last_rd;
        bad    = 1'b0;
        if (ph == PH_SHUT && op != OP_NONE)
            bad = 1'b1;
        if (slot && op == OP_BOTH)
            bad = 1'b1;
        if (slot && op == OP_WRITE && last_rd)
            bad = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_OPEN;
            last_rd <= 1'b0;
            err     <= 1'b0;
        end else begin
            ph <= next_phase(ph);
            if (slot)
                last_rd <= acc_rd;
            if (bad)
                err <= 1'b1;
        end
    end
endmodule

// File: rtl/ddrb4_wbuf.sv
module ddrb4_wbuf
    import ddrb4_pkg::*;
#(
    parameter int GRP_W  = 6,
    parameter int DATA_W = 36,
    localparam int LANES = DATA_W / BYTE_W
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             acc_wr,
    input  logic [GRP_W-1:0]                 acc_grp,
    input  logic [DATA_W-1:0]                wr_data,
    input  logic [LANES-1:0]                 wr_ben,
    output logic                             commit_en,
    output logic                             buf_vld,
    output logic [GRP_W-1:0]                 buf_grp,
    output logic [BURST-1:0][DATA_W-1:0]     buf_data,
    output logic [BURST-1:0][LANES-1:0]      buf_mask
);
    localparam int FIRST = WR_LEAD_PH - 1;
    localparam int TOK   = FIRST + BURST;

    logic [TOK-1:0]   wtok;
    logic [GRP_W-1:0] pend_grp;

    assign commit_en = wtok[FIRST] && buf_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            wtok     <= '0;
            pend_grp <= '0;
            buf_vld  <= 1'b0;
            buf_grp  <= '0;
            buf_data <= '0;
            buf_mask <= '0;
        end else begin
            wtok <= {wtok[TOK-2:0], acc_wr};
            if (acc_wr)
                pend_grp <= acc_grp;
            if (wtok[FIRST]) begin
                buf_vld  <= 1'b1;
                buf_grp  <= pend_grp;
                buf_mask <= '0;
            end
            for (int j = 0; j < BURST; j++) begin
                if (wtok[FIRST + j]) begin
                    buf_data[j] <= wr_data;
                    buf_mask[j] <= wr_ben;
                end
            end
        end
    end
endmodule

// File: rtl/ddrb4_array.sv
module ddrb4_array
    import ddrb4_pkg::*;
#(
    parameter int GROUPS = 64,
    parameter int DATA_W = 36,
    localparam int LANES  = DATA_W / BYTE_W,
    localparam int GRP_W  = $clog2(GROUPS),
    localparam int WORD_W = GRP_W + 2,
    localparam int WORDS  = GROUPS * BURST
) (
    input  logic                         clk,
    input  logic                         commit_en,
    input  logic                         buf_vld,
    input  logic [GRP_W-1:0]             buf_grp,
    input  logic [BURST-1:0][DATA_W-1:0] buf_data,
    input  logic [BURST-1:0][LANES-1:0]  buf_mask,
    input  logic [WORD_W-1:0]            rd_addr,
    output logic [DATA_W-1:0]            rd_word
);
    logic [DATA_W-1:0] mem [WORDS];
    logic [DATA_W-1:0] raw;
    logic              hit;
    logic [1:0]        off;

    always_ff @(posedge clk) begin
        if (commit_en) begin
            for (int w = 0; w < BURST; w++) begin
                for (int l = 0; l < LANES; l++) begin
                    if (buf_mask[w][l])
                        mem[{buf_grp, 2'(w)}][l*BYTE_W +: BYTE_W] <= buf_data[w][l*BYTE_W +: BYTE_W];
                end
            end
        end
    end

    always_comb begin
        raw = mem[rd_addr];
        off = rd_addr[1:0];
        hit = buf_vld && (buf_grp == rd_addr[WORD_W-1:2]);
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign rd_word[l*BYTE_W +: BYTE_W] = (hit && buf_mask[off][l])
                                           ? buf_data[off][l*BYTE_W +: BYTE_W]
                                           : raw[l*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/ddrb4_rdpipe.sv
module ddrb4_rdpipe
    import ddrb4_pkg::*;
#(
    parameter int GRP_W  = 6,
    parameter int DATA_W = 36,
    localparam int WORD_W = GRP_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_rd,
    input  logic [GRP_W-1:0]  acc_grp,
    input  logic [DATA_W-1:0] word_in,
    output logic [WORD_W-1:0] fetch_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_vld,
    output logic              rd_oe,
    output logic              echo_strb
);
    localparam int L = RD_LAT_PH;

    logic [L-1:0]     pv;
    logic [GRP_W-1:0] pg [L];
    logic             act;
    logic [1:0]       beat;
    logic [GRP_W-1:0] bgrp;
    logic             start;
    logic             drive;

    always_ff @(posedge clk) begin
        if (rst) pv <= '0;
        else     pv <= {pv[L-2:0], acc_rd};
    end

    for (genvar i = 0; i < L; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk) pg[0] <= acc_grp;
        end else begin : g_body
            always_ff @(posedge clk) pg[i] <= pg[i-1];
        end
    end

    always_comb begin
        start      = pv[L-1];
        drive      = start || act;
        fetch_addr = start ? {pg[L-1], 2'b00} : {bgrp, beat};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act       <= 1'b0;
            beat      <= 2'd0;
            bgrp      <= '0;
            rd_vld    <= 1'b0;
            rd_oe     <= 1'b0;
            rd_data   <= '0;
            echo_strb <= 1'b0;
        end else begin
            if (start) begin
                bgrp <= pg[L-1];
                beat <= 2'd1;
                act  <= 1'b1;
            end else if (act) begin
                beat <= beat + 2'd1;
                act  <= (beat != 2'd3);
            end
            rd_vld <= drive;
            rd_oe  <= drive;
            if (drive) begin
                rd_data   <= word_in;
                echo_strb <= ~echo_strb;
            end
        end
    end
endmodule

// File: rtl/ddrb4_sram_core.sv
module ddrb4_sram_core
    import ddrb4_pkg::*;
#(
    parameter int GROUPS = 64,
    parameter int DATA_W = 36,
    localparam int LANES  = DATA_W / BYTE_W,
    localparam int GRP_W  = $clog2(GROUPS),
    localparam int WORD_W = GRP_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    output logic              cmd_slot,
    input  logic              cmd_rd,
    input  logic              cmd_wr,
    input  logic [GRP_W-1:0]  cmd_grp,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_ben,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_oe,
    output logic              rd_vld,
    output logic              echo_strb,
    output logic              proto_err
);
    logic                         acc_rd;
    logic                         acc_wr;
    logic                         commit_en;
    logic                         buf_vld;
    logic [GRP_W-1:0]             buf_grp;
    logic [BURST-1:0][DATA_W-1:0] buf_data;
    logic [BURST-1:0][LANES-1:0]  buf_mask;
    logic [WORD_W-1:0]            fetch_addr;
    logic [DATA_W-1:0]            fetch_word;

    ddrb4_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .cmd_rd (cmd_rd),
        .cmd_wr (cmd_wr),
        .slot   (cmd_slot),
        .acc_rd (acc_rd),
        .acc_wr (acc_wr),
        .err    (proto_err)
    );

    ddrb4_wbuf #(.GRP_W(GRP_W), .DATA_W(DATA_W)) u_wbuf (
        .clk       (clk),
        .rst       (rst),
        .acc_wr    (acc_wr),
        .acc_grp   (cmd_grp),
        .wr_data   (wr_data),
        .wr_ben    (wr_ben),
        .commit_en (commit_en),
        .buf_vld   (buf_vld),
        .buf_grp   (buf_grp),
        .buf_data  (buf_data),
        .buf_mask  (buf_mask)
    );

    ddrb4_array #(.GROUPS(GROUPS), .DATA_W(DATA_W)) u_array (
        .clk       (clk),
        .commit_en (commit_en),
        .buf_vld   (buf_vld),
        .buf_grp   (buf_grp),
        .buf_data  (buf_data),
        .buf_mask  (buf_mask),
        .rd_addr   (fetch_addr),
        .rd_word   (fetch_word)
    );

    ddrb4_rdpipe #(.GRP_W(GRP_W), .DATA_W(DATA_W)) u_rdpipe (
        .clk        (clk),
        .rst        (rst),
        .acc_rd     (acc_rd),
        .acc_grp    (cmd_grp),
        .word_in    (fetch_word),
        .fetch_addr (fetch_addr),
        .rd_data    (rd_data),
        .rd_vld     (rd_vld),
        .rd_oe      (rd_oe),
        .echo_strb  (echo_strb)
    );
endmodule

// File: rtl/ddrb4_chk.sv
module ddrb4_chk (
    input logic clk,
    input logic rst,
    input logic cmd_slot,
    input logic cmd_rd,
    input logic cmd_wr,
    input logic rd_vld,
    input logic rd_oe,
    input logic echo_strb,
    input logic proto_err
);
    a_r2_slot_every_fourth: assert property (@(posedge clk) disable iff (rst)
        cmd_slot |=> !cmd_slot ##1 !cmd_slot ##1 !cmd_slot ##1 cmd_slot);

    a_r4_first_beat_latency: assert property (@(posedge clk) disable iff (rst)
        (cmd_slot && cmd_rd && !cmd_wr) |=> ##5 rd_vld);

    a_r5_four_beat_run: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_vld) |=> rd_vld ##1 rd_vld ##1 rd_vld);

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err);

    a_r9_reset_quiet: assert property (@(posedge clk)
        rst |=> (!rd_oe && !rd_vld && !proto_err && !echo_strb));

    a_r10_echo_on_beat: assert property (@(posedge clk) disable iff (rst)
        (echo_strb != $past(echo_strb)) |-> rd_vld);
endmodule

bind ddrb4_sram_core ddrb4_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_slot  (cmd_slot),
    .cmd_rd    (cmd_rd),
    .cmd_wr    (cmd_wr),
    .rd_vld    (rd_vld),
    .rd_oe     (rd_oe),
    .echo_strb (echo_strb),
    .proto_err (proto_err)
);

// File: tb/sim_ddrb4_sram_core.sv
`timescale 1ns/1ps
module sim_ddrb4_sram_core;
    localparam int DW    = 36;
    localparam int GRPS  = 64;
    localparam int LN    = 4;
    localparam int NPH   = 2400;
    localparam int NSLOT = NPH / 4;
    localparam int KILL  = NSLOT - 28;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_slot;
    logic          cmd_rd = 1'b0;
    logic          cmd_wr = 1'b0;
    logic [5:0]    cmd_grp = '0;
    logic [DW-1:0] wr_data = '0;
    logic [LN-1:0] wr_ben = '0;
    logic [DW-1:0] rd_data;
    logic          rd_oe;
    logic          rd_vld;
    logic          echo_strb;
    logic          proto_err;

    always #2 clk = ~clk;

    ddrb4_sram_core u0 (
        .clk(clk), .rst(rst), .cmd_slot(cmd_slot), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
        .cmd_grp(cmd_grp), .wr_data(wr_data), .wr_ben(wr_ben), .rd_data(rd_data),
        .rd_oe(rd_oe), .rd_vld(rd_vld), .echo_strb(echo_strb), .proto_err(proto_err)
    );

    logic          in_rd   [NPH];
    logic          in_wr   [NPH];
    logic [5:0]    in_grp  [NPH];
    logic [DW-1:0] in_data [NPH];
    logic [LN-1:0] in_ben  [NPH];
    logic          ex_vld  [NPH];
    logic [DW-1:0] ex_data [NPH];
    string         ex_tag  [NPH];
    logic [DW-1:0] model   [GRPS*4];
    int            err_from;
    int            checks = 0;
    int            failures = 0;
    bit            done = 1'b0;

    function automatic logic [DW-1:0] rnd_word();
        logic [63:0] t;
        t = {$urandom(), $urandom()};
        return t[DW-1:0];
    endfunction

    function automatic logic [DW-1:0] merge_lanes(input logic [DW-1:0] old,
                                                  input logic [DW-1:0] nw,
                                                  input logic [LN-1:0] ben);
        logic [DW-1:0] r;
        r = old;
        for (int l = 0; l < LN; l++)
            if (ben[l]) r[l*9 +: 9] = nw[l*9 +: 9];
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // legal write: beats at n0+2..n0+5, model updated in program order (R3, R6)
    task automatic gen_write(input int s, input int g, input bit full);
        int n0 = 4 * s;
        in_wr[n0]  = 1'b1;
        in_grp[n0] = 6'(g);
        for (int j = 0; j < 4; j++) begin
            logic [DW-1:0] d = rnd_word();
            logic [LN-1:0] b = full ? 4'hF : 4'($urandom());
            in_data[n0+2+j] = d;
            in_ben[n0+2+j]  = b;
            model[g*4+j]    = merge_lanes(model[g*4+j], d, b);
        end
    endtask

    // legal read: beat j+1 visible after edge n0+5+j (R4, R1)
    task automatic gen_read(input int s, input int g, input string tag);
        int n0 = 4 * s;
        in_rd[n0]  = 1'b1;
        in_grp[n0] = 6'(g);
        for (int j = 0; j < 4; j++) begin
            ex_vld[n0+5+j]  = 1'b1;
            ex_data[n0+5+j] = model[g*4+j];
            ex_tag[n0+5+j]  = tag;
        end
    endtask

    task automatic drive(input int n);
        if (n < NPH) begin
            cmd_rd  = in_rd[n];
            cmd_wr  = in_wr[n];
            cmd_grp = in_grp[n];
            wr_data = in_data[n];
            wr_ben  = in_ben[n];
        end else begin
            cmd_rd = 1'b0; cmd_wr = 1'b0; cmd_grp = '0; wr_data = '0; wr_ben = '0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R4 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bit prev_rd;
        bit exp_echo;
        void'($urandom(32'h5eed_d4b4));
        err_from = NPH;
        for (int n = 0; n < NPH; n++) begin
            in_rd[n] = 1'b0; in_wr[n] = 1'b0;
            in_grp[n] = 6'($urandom());
            in_data[n] = rnd_word();
            in_ben[n] = 4'($urandom());
            ex_vld[n] = 1'b0; ex_data[n] = '0; ex_tag[n] = "";
        end
        for (int w = 0; w < GRPS*4; w++) model[w] = '0;

        // odd-phase noise commands before the illegal section (R8: ignored, no flag)
        for (int s = 0; s < KILL; s++) begin
            in_rd[4*s+1] = 1'($urandom()); in_wr[4*s+1] = 1'($urandom());
            in_rd[4*s+3] = 1'($urandom()); in_wr[4*s+3] = 1'($urandom());
        end

        // directed: back-to-back full writes, late-write coherency
        for (int s = 0; s < 8; s++) gen_write(s, s, 1'b1);
        gen_read(8, 7, "R7");
        gen_read(9, 0, "R1");
        gen_write(11, 2, 1'b0);
        gen_write(12, 2, 1'b0);
        gen_read(13, 2, "R7");
        gen_read(14, 3, "R5");
        gen_write(16, 4, 1'b0);
        gen_read(17, 4, "R6");

        // random bursts
        prev_rd = 1'b1;
        for (int s = 18; s < KILL - 1; s++) begin
            int op = $urandom_range(0, 2);
            int g  = $urandom_range(0, 7);
            if (op == 2 && prev_rd) op = 1;
            if (op == 1) gen_read(s, g, "R4");
            else if (op == 2) gen_write(s, g, 1'b0);
            prev_rd = (op == 1);
        end

        // illegal section (R8)
        gen_write(KILL, 5, 1'b1);
        gen_read(KILL+1, 5, "R7");
        in_wr[4*(KILL+2)] = 1'b1; in_grp[4*(KILL+2)] = 6'd5;
        err_from = 4*(KILL+2);
        gen_read(KILL+4, 5, "R8");
        in_rd[4*(KILL+5)] = 1'b1; in_wr[4*(KILL+5)] = 1'b1; in_grp[4*(KILL+5)] = 6'd6;
        gen_read(KILL+6, 6, "R8");
        in_rd[4*(KILL+7)+2] = 1'b1; in_grp[4*(KILL+7)+2] = 6'd1;
        gen_read(KILL+8, 1, "R8");

        // reset state (R9, R2)
        drive(NPH);
        repeat (3) @(negedge clk);
        chk(rd_vld == 1'b0, "R9", "rd_vld in reset", 64'(rd_vld), 64'd0);
        chk(rd_oe == 1'b0, "R9", "rd_oe in reset", 64'(rd_oe), 64'd0);
        chk(proto_err == 1'b0, "R9", "proto_err in reset", 64'(proto_err), 64'd0);
        chk(echo_strb == 1'b0, "R9", "echo_strb in reset", 64'(echo_strb), 64'd0);
        chk(cmd_slot == 1'b1, "R2", "cmd_slot before first edge", 64'(cmd_slot), 64'd1);
        rst = 1'b0;
        drive(0);

        exp_echo = 1'b0;
        for (int n = 0; n < NPH; n++) begin
            @(negedge clk);
            exp_echo ^= ex_vld[n];
            chk(rd_vld == ex_vld[n], "R5", "rd_vld", 64'(rd_vld), 64'(ex_vld[n]));
            chk(rd_oe == ex_vld[n], "R5", "rd_oe", 64'(rd_oe), 64'(ex_vld[n]));
            if (ex_vld[n])
                chk(rd_data == ex_data[n], ex_tag[n], "rd_data", 64'(rd_data), 64'(ex_data[n]));
            chk(proto_err == (n >= err_from), "R8", "proto_err", 64'(proto_err), 64'(n >= err_from));
            chk(echo_strb == exp_echo, "R10", "echo_strb", 64'(echo_strb), 64'(exp_echo));
            chk(cmd_slot == ((n+1) % 4 == 0), "R2", "cmd_slot", 64'(cmd_slot), 64'((n+1) % 4 == 0));
            drive(n + 1);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule